// File: doc/BRIEF.md
# Receive Line Glitch Filter

This block cleans up an asynchronous serial receive line before the receiver's start-bit and bit-sampling logic sees it. The raw pin first crosses into the system clock domain through a flop synchronizer. After that it is sampled only on cycles where a base-clock enable from the baud prescaler is high. Each sample moves through a two-register history. A new level is copied to the filtered output only when the two most recent samples agree.

The result is that a level seen on just one sampling tick never reaches the receiver. A genuine edge reaches the filtered output a fixed three ticks after it is first captured. On every tick where the two history registers disagree, a one-clock `noise_detected` pulse marks the rejected sample.

All storage runs on the single system clock and resets to the idle (high) line level, so no false start bit appears after reset. The filtered level and the noise flag are plain level/pulse outputs. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rx_noise_filter`

## Requirements
- R1: While `rst_n` is low, `rx_filt` is 1 and `noise_detected` is 0. Both history registers also reset to 1, so with the pin high the first tick after reset raises no flag and leaves `rx_filt` at 1.
- R2: Sampling state moves only on system clock edges where `base_tick` is 1. With `base_tick` held at 0, `rx_filt` and `noise_detected` stay constant, and pin activity in that time is not captured.
- R3: On each tick, the older history register takes the previous value of the newer one, and the newer one takes the synchronized pin.
- R4: On a tick where the two history registers are equal, `rx_filt` loads their value. On a tick where they differ, `rx_filt` keeps its value.
- R5: A pin level captured on only one tick, between ticks that capture the opposite level, never appears on `rx_filt`. This holds for both a low glitch and a high glitch.
- R6: A pin level captured on two consecutive ticks appears on `rx_filt` after the edge of the next tick, even if the pin has already returned.
- R7: A clean level change first captured on tick k shows on `rx_filt` right after tick k+2, which is three ticks counting tick k itself.
- R8: `noise_detected` is 1 for exactly the one clock after a tick whose history registers disagree, and 0 at all other times.
- R9: `rx_filt` changes only in the clock that follows a tick and comes straight from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | Base-clock enable from the prescaler, one clock wide per tick |
| rx_pin | input | 1 | Raw asynchronous receive line |
| rx_filt | output | 1 | Filtered receive level |
| noise_detected | output | 1 | One-clock pulse per rejected mismatch |

## Verification
The hardest case to reach from the ports is a sample history that is exactly on the edge of acceptance. Examples are a level captured on two ticks and then dropped, or a glitch that returns right away. Here a single mis-timed sample moves the filtered edge or lets a glitch through. To reach these cases, the stimulus drives one pin level per tick and holds it through the synchronizer before the enable pulse, so each tick captures a known value. A table of per-tick levels then walks single-sample glitches of both polarities, a two-sample pulse, and clean edges. Directed tests hold the enable low through pin activity and apply reset in the middle of a run.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam logic        LINE_IDLE       = 1'b1;

  typedef struct packed {
    logic newer;
    logic older;
  } samp_pair_t;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxf_sample_chain.sv
module rxf_sample_chain
  import rxf_pkg::*;
#(
  parameter logic RST_VAL = LINE_IDLE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       d,
  output samp_pair_t pair,
  output logic       agree
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair.newer <= RST_VAL;
      pair.older <= RST_VAL;
    end else if (tick) begin
      pair.newer <= d;
      pair.older <= pair.newer;
    end
  end

  assign agree = (pair.newer == pair.older);
endmodule

// File: rtl/rxf_load_stage.sv
module rxf_load_stage
  import rxf_pkg::*;
#(
  parameter logic RST_VAL = LINE_IDLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic agree,
  input  logic level,
  output logic filt,
  output logic mismatch
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt     <= RST_VAL;
      mismatch <= 1'b0;
    end else begin
      mismatch <= tick & ~agree;
      if (tick && agree) filt <= level;
    end
  end
endmodule

// File: rtl/rx_noise_filter.sv
module rx_noise_filter
  import rxf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter logic        IDLE_LEVEL  = LINE_IDLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_tick,
  input  logic rx_pin,
  output logic rx_filt,
  output logic noise_detected
);
  logic       pin_sync;
  samp_pair_t pair;
  logic       agree;
  logic       samp_new;
  logic       samp_old;

  rxf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_pin), .q(pin_sync)
  );

  rxf_sample_chain #(.RST_VAL(IDLE_LEVEL)) u_chain (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .d(pin_sync),
    .pair(pair), .agree(agree)
  );

  assign samp_new = pair.newer;
  assign samp_old = pair.older;

  rxf_load_stage #(.RST_VAL(IDLE_LEVEL)) u_load (
    .clk(clk), .rst_n(rst_n), .tick(base_tick), .agree(agree),
    .level(samp_new), .filt(rx_filt), .mismatch(noise_detected)
  );
endmodule

// File: rtl/rx_noise_filter_chk.sv
module rx_noise_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic base_tick,
  input logic rx_filt,
  input logic noise_detected,
  input logic samp_new,
  input logic samp_old
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> ($stable(rx_filt) && $stable(samp_new) && $stable(samp_old))); // R2
  AST_SHIFT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> (samp_old == $past(samp_new))); // R3
  AST_LOAD_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && samp_new == samp_old) |=> (rx_filt == $past(samp_new))); // R4
  AST_HOLD_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && samp_new != samp_old) |=> $stable(rx_filt)); // R4
  AST_FLAG_ON_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && samp_new != samp_old) |=> noise_detected); // R8
  AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(base_tick && samp_new != samp_old) |=> !noise_detected); // R8
  AST_OUT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_filt != $past(rx_filt)) |-> $past(base_tick)); // R9
endmodule

bind rx_noise_filter rx_noise_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rx_filt(rx_filt),
  .noise_detected(noise_detected), .samp_new(samp_new), .samp_old(samp_old)
);

// File: tb/rx_noise_filter_test.sv
`timescale 1ns/1ps
module rx_noise_filter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_tick = 1'b0;
  logic rx_pin = 1'b1;
  logic rx_filt;
  logic noise_detected;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rx_noise_filter uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .rx_pin(rx_pin),
    .rx_filt(rx_filt), .noise_detected(noise_detected)
  );

  // {pin level captured on the tick, expected rx_filt, expected noise_detected}
  localparam logic [2:0] VEC [0:18] = '{
    3'b010, 3'b111, 3'b111, 3'b110,          // R5 low glitch
    3'b010, 3'b011, 3'b000,                  // R7 clean fall
    3'b100, 3'b001, 3'b001, 3'b000,          // R5 high glitch
    3'b100, 3'b101, 3'b010, 3'b011, 3'b000,  // R6 two-sample pulse
    3'b100, 3'b101, 3'b110                   // R7 clean rise
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one tick capturing level v; returns at a negedge after the tick edge
  task automatic step(input logic v);
    @(negedge clk) rx_pin = v;
    @(negedge clk);
    @(negedge clk);
    base_tick = 1'b1;
    @(negedge clk);
    base_tick = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset rx_filt", rx_filt, 1'b1);
    check("R1 reset noise_detected", noise_detected, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 19; i++) begin
      step(VEC[i][2]);
      check("R4/R5/R6/R7 rx_filt", rx_filt, VEC[i][1]);
      check("R8 noise_detected", noise_detected, VEC[i][0]);
    end

    // R2: no ticks while the pin moves
    @(negedge clk) rx_pin = 1'b0;
    repeat (20) @(negedge clk);
    check("R2 rx_filt without tick", rx_filt, 1'b1);
    check("R2 flag without tick", noise_detected, 1'b0);
    step(1'b1);
    check("R2 low pin not captured (flag)", noise_detected, 1'b0);
    check("R2 rx_filt", rx_filt, 1'b1);

    // R8 pulse width, R7 fall latency
    step(1'b0);
    check("R7 tick1 rx_filt", rx_filt, 1'b1);
    step(1'b0);
    check("R8 flag on mismatch", noise_detected, 1'b1);
    @(negedge clk);
    check("R8 flag one clock", noise_detected, 1'b0);
    step(1'b0);
    check("R7 rx_filt third tick", rx_filt, 1'b0);

    // R1 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset rx_filt", rx_filt, 1'b1);
    check("R1 mid reset flag", noise_detected, 1'b0);
    rx_pin = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    step(1'b1);
    check("R1 idle history flag", noise_detected, 1'b0);
    check("R1 idle history rx_filt", rx_filt, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule